// File: doc/BRIEF.md
# Floating-Point Status Flags and Branch Condition Evaluator

This block keeps the 32-bit status word of a floating-point unit. When the arithmetic datapath reports a result, the block reads the raw IEEE double-precision bit pattern. It replaces the four condition flags with a new set: negative, zero, infinity and not-a-number. The other status bits are left as they were. Software can also overwrite the whole word in one cycle, and the current value is always visible on a read port.

A conditional-branch unit sends the block a 6-bit condition code. The block tests that code against the registered flags and returns one "condition holds" bit in the same cycle. The predicate set is aware of unordered operands: the ordered comparisons are false when NaN is set, and the unordered comparisons are true when NaN is set. A code that is not in the supported set gives a false condition and, while a request is present, an error pulse.

Top module: `fpsc_status`

## Requirements
- R1: After reset the status word reads 0x0000_0000.
- R2: A flag update sets the negative flag (status bit 27) exactly when bit 63 of the result is 1.
- R3: A flag update sets the zero flag (status bit 26) exactly when result bits 62:0 are all zero, so a negative zero sets both negative and zero.
- R4: A flag update sets the infinity flag (status bit 25) exactly when result bits 62:0 equal 0x7FF0_0000_0000_0000.
- R5: A flag update sets the NaN flag (status bit 24) exactly when exponent bits 62:52 are all ones and mantissa bits 51:0 are nonzero.
- R6: A flag update changes bits 27:24 and nothing else. All four flag bits are recomputed, and bits 31:28 and 23:0 keep their values. The new word appears on the read port one clock after the strobe.
- R7: A software write loads the full 32-bit word one clock later and takes priority over a flag update in the same cycle.
- R8: With neither strobe high, the status word is unchanged, whatever is on the result input.
- R9: Code 0x00 is false, 0x0F is true, 0x01 equals Z, and 0x0E equals not Z.
- R10: Ordered comparisons: 0x12 = !(NaN|Z|N), 0x13 = Z|!(NaN|N), 0x14 = N&!(NaN|Z), 0x15 = Z|(N&!NaN).
- R11: Unordered comparisons: 0x1A = NaN|!(N|Z), 0x1B = NaN|Z|!N, 0x1C = NaN|(N&!Z), 0x1D = NaN|Z|N.
- R12: Any other code gives a false condition. The error output is high in the same cycle only when an evaluation request accompanies such a code, and it is never high without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| upd_valid | input | 1 | Flag-update strobe for the result on upd_result |
| upd_result | input | 64 | Raw double-precision result bit pattern |
| sw_wr_en | input | 1 | Full-word software write strobe |
| sw_wr_data | input | 32 | Software write data |
| status_q | output | 32 | Current status word |
| eval_req | input | 1 | Condition evaluation request |
| eval_code | input | 6 | Condition code to test |
| cond_true | output | 1 | Condition holds on the registered flags (combinational) |
| cond_err | output | 1 | Unsupported code seen with a request (combinational) |

## Verification
The flags are the block's only hidden state, and they are always visible on the status port. A wrong classification or a lost bit outside the flag field therefore shows on the port one clock after the strobe that caused it. A wrong predicate shows on cond_true in the same cycle as the request. For that reason every one of the 64 codes is checked against all 16 flag combinations. Priority errors between the two write paths show one cycle after a cycle in which both strobes are high.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
  localparam int FLAG_N_BIT   = 27;
  localparam int FLAG_Z_BIT   = 26;
  localparam int FLAG_INF_BIT = 25;
  localparam int FLAG_NAN_BIT = 24;
  localparam int FLAG_LSB     = FLAG_NAN_BIT;
  localparam int FLAG_CNT     = 4;

  typedef struct packed {
    logic neg;
    logic zero;
    logic inf;
    logic nan;
  } fcc_t;

  typedef enum logic [5:0] {
    CC_NEVER  = 6'h00,
    CC_EQ     = 6'h01,
    CC_NE     = 6'h0E,
    CC_ALWAYS = 6'h0F,
    CC_OGT    = 6'h12,
    CC_OGE    = 6'h13,
    CC_OLT    = 6'h14,
    CC_OLE    = 6'h15,
    CC_UGT    = 6'h1A,
    CC_UGE    = 6'h1B,
    CC_ULT    = 6'h1C,
    CC_ULE    = 6'h1D
  } cond_code_e;
endpackage

// File: rtl/fpsc_classify.sv
module fpsc_classify
  import fpsc_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int RES_W = EXP_W + MAN_W + 1
) (
  input  logic [RES_W-1:0] result,
  output fcc_t             flags
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones;
  logic             man_any;
  logic             exp_any;

  always_comb begin
    exp_f    = result[RES_W-2 -: EXP_W];
    man_f    = result[MAN_W-1:0];
    exp_ones = &exp_f;
    exp_any  = |exp_f;
    man_any  = |man_f;

    flags.neg  = result[RES_W-1];
    flags.zero = ~exp_any & ~man_any;
    flags.inf  = exp_ones & ~man_any;
    flags.nan  = exp_ones & man_any;
  end
endmodule

// File: rtl/fpsc_cond_eval.sv
module fpsc_cond_eval
  import fpsc_pkg::*;
(
  input  logic [5:0] code,
  input  fcc_t       flags,
  output logic       hit,
  output logic       known
);
  logic n, z, u;

  always_comb begin
    n     = flags.neg;
    z     = flags.zero;
    u     = flags.nan;
    hit   = 1'b0;
    known = 1'b1;
    case (code)
      CC_NEVER:  hit = 1'b0;
      CC_ALWAYS: hit = 1'b1;
      CC_EQ:     hit = z;
      CC_NE:     hit = ~z;
      CC_OGT:    hit = ~(u | z | n);
      CC_OGE:    hit = z | ~(u | n);
      CC_OLT:    hit = n & ~(u | z);
      CC_OLE:    hit = z | (n & ~u);
      CC_UGT:    hit = u | ~(n | z);
      CC_UGE:    hit = u | z | ~n;
      CC_ULT:    hit = u | (n & ~z);
      CC_ULE:    hit = u | z | n;
      default: begin
        hit   = 1'b0;
        known = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fpsc_status.sv
module fpsc_status
  import fpsc_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int EXP_W  = 11,
  parameter int MAN_W  = 52,
  localparam int RES_W = EXP_W + MAN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [RES_W-1:0]  upd_result,
  input  logic              sw_wr_en,
  input  logic [STAT_W-1:0] sw_wr_data,
  output logic [STAT_W-1:0] status_q,
  input  logic              eval_req,
  input  logic [5:0]        eval_code,
  output logic              cond_true,
  output logic              cond_err
);
  fcc_t              new_flags;
  fcc_t              cur_flags;
  logic [STAT_W-1:0] status_d;
  logic              status_en;
  logic              code_known;

  fpsc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
    .result (upd_result),
    .flags  (new_flags)
  );

  // next-state: software write first, then flag merge
  always_comb begin
    status_en = sw_wr_en | upd_valid;
    status_d  = status_q;
    if (sw_wr_en) begin
      status_d = sw_wr_data;
    end else if (upd_valid) begin
      status_d[FLAG_LSB +: FLAG_CNT] = new_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  assign cur_flags = fcc_t'(status_q[FLAG_LSB +: FLAG_CNT]);

  fpsc_cond_eval u_eval (
    .code  (eval_code),
    .flags (cur_flags),
    .hit   (cond_true),
    .known (code_known)
  );

  assign cond_err = eval_req & ~code_known;
endmodule

// File: rtl/fpsc_status_chk.sv
module fpsc_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        upd_valid,
  input logic [63:0] upd_result,
  input logic        sw_wr_en,
  input logic [31:0] sw_wr_data,
  input logic [31:0] status_q,
  input logic        eval_req,
  input logic [5:0]  eval_code,
  input logic        cond_true,
  input logic        cond_err
);
  AST_ERR_ONLY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cond_err |-> eval_req); // R12

  AST_ALWAYS_CODE_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_code == 6'h0F) |-> cond_true); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid && !sw_wr_en) |=> $stable(status_q)); // R8

  AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> (status_q == $past(sw_wr_data))); // R7

  AST_NONFLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !sw_wr_en) |=> (status_q[31:28] == $past(status_q[31:28]) &&
                                  status_q[23:0] == $past(status_q[23:0]))); // R6

  AST_SIGN_TO_N: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !sw_wr_en) |=> (status_q[27] == $past(upd_result[63]))); // R2

  AST_ZERO_INF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !sw_wr_en) |=> !(status_q[26] && status_q[25])); // R4

  AST_NAN_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !sw_wr_en && (&upd_result[62:52]) && (|upd_result[51:0]))
      |=> status_q[24]); // R5

  AST_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !sw_wr_en && upd_result == 64'h8000_0000_0000_0000)
      |=> (status_q[27:26] == 2'b11)); // R3
endmodule

bind fpsc_status fpsc_status_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_valid  (upd_valid),
  .upd_result (upd_result),
  .sw_wr_en   (sw_wr_en),
  .sw_wr_data (sw_wr_data),
  .status_q   (status_q),
  .eval_req   (eval_req),
  .eval_code  (eval_code),
  .cond_true  (cond_true),
  .cond_err   (cond_err)
);

// File: tb/tb_fpsc_status.sv
module tb_fpsc_status;
  logic        clk;
  logic        rst_n;
  logic        upd_valid;
  logic [63:0] upd_result;
  logic        sw_wr_en;
  logic [31:0] sw_wr_data;
  logic [31:0] status_q;
  logic        eval_req;
  logic [5:0]  eval_code;
  logic        cond_true;
  logic        cond_err;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  typedef struct {
    bit          is_eval;
    string       req;
    logic [31:0] exp_status;
    logic        exp_cond;
    logic        exp_err;
  } item_t;

  item_t       sb_q[$];
  logic [31:0] model;

  fpsc_status dut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_result(upd_result),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .status_q(status_q),
    .eval_req(eval_req), .eval_code(eval_code), .cond_true(cond_true),
    .cond_err(cond_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] apply_flags(logic [31:0] s, logic [63:0] r);
    logic [31:0] o;
    o = s & ~32'h0F00_0000;
    if (r[63]) o[27] = 1'b1;
    if (r[62:0] == 63'd0) o[26] = 1'b1;
    if (r[62:0] == 63'h7FF0_0000_0000_0000) o[25] = 1'b1;
    if (r[62:52] == 11'h7FF && r[51:0] != 52'd0) o[24] = 1'b1;
    return o;
  endfunction

  function automatic logic spec_cond(logic [5:0] c, logic [31:0] s);
    logic n, z, u;
    n = s[27]; z = s[26]; u = s[24];
    case (c)
      6'h00: return 1'b0;
      6'h0F: return 1'b1;
      6'h01: return z;
      6'h0E: return !z;
      6'h12: return !(u || z || n);
      6'h13: return z || !(u || n);
      6'h14: return n && !(u || z);
      6'h15: return z || (n && !u);
      6'h1A: return u || !(n || z);
      6'h1B: return u || z || !n;
      6'h1C: return u || (n && !z);
      6'h1D: return u || z || n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit is_known(logic [5:0] c);
    return c inside {6'h00, 6'h0F, 6'h01, 6'h0E, 6'h12, 6'h13, 6'h14, 6'h15,
                     6'h1A, 6'h1B, 6'h1C, 6'h1D};
  endfunction

  function automatic string code_req(logic [5:0] c);
    if (c inside {6'h00, 6'h0F, 6'h01, 6'h0E}) return "R9";
    if (c inside {6'h12, 6'h13, 6'h14, 6'h15}) return "R10";
    if (c inside {6'h1A, 6'h1B, 6'h1C, 6'h1D}) return "R11";
    return "R12";
  endfunction

  task automatic idle_inputs();
    upd_valid = 1'b0; upd_result = '0; sw_wr_en = 1'b0; sw_wr_data = '0;
    eval_req = 1'b0; eval_code = '0;
  endtask

  task automatic push_status(string req);
    item_t it;
    it.is_eval = 1'b0; it.req = req; it.exp_status = model;
    it.exp_cond = 1'b0; it.exp_err = 1'b0;
    sb_q.push_back(it);
  endtask

  task automatic drv_update(logic [63:0] r, string req);
    @(negedge clk);
    idle_inputs();
    upd_valid = 1'b1; upd_result = r;
    model = apply_flags(model, r);
    push_status(req);
  endtask

  task automatic drv_write(logic [31:0] d, string req);
    @(negedge clk);
    idle_inputs();
    sw_wr_en = 1'b1; sw_wr_data = d;
    model = d;
    push_status(req);
  endtask

  task automatic drv_both(logic [31:0] d, logic [63:0] r);
    @(negedge clk);
    idle_inputs();
    sw_wr_en = 1'b1; sw_wr_data = d; upd_valid = 1'b1; upd_result = r;
    model = d;
    push_status("R7");
  endtask

  task automatic drv_noise(logic [63:0] r);
    @(negedge clk);
    idle_inputs();
    upd_result = r; sw_wr_data = 32'hDEAD_BEEF;
    push_status("R8");
  endtask

  task automatic drv_eval(logic [5:0] c, logic req);
    item_t it;
    @(negedge clk);
    idle_inputs();
    eval_req = req; eval_code = c;
    it.is_eval = 1'b1;
    it.req = req ? code_req(c) : "R12";
    it.exp_status = model;
    it.exp_cond = spec_cond(c, model);
    it.exp_err = req && !is_known(c);
    sb_q.push_back(it);
  endtask

  // monitor: compare one item per cycle, 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (it.is_eval) begin
        if (cond_true !== it.exp_cond || cond_err !== it.exp_err) begin
          errors++;
          $display("FAIL %s code=%02h flags=%h: cond/err got %b/%b exp %b/%b",
                   it.req, eval_code, status_q[27:24], cond_true, cond_err,
                   it.exp_cond, it.exp_err);
        end
      end else if (status_q !== it.exp_status) begin
        errors++;
        $display("FAIL %s status got %h exp %h", it.req, status_q, it.exp_status);
      end
    end
  end

  initial begin
    idle_inputs();
    model = 32'h0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset value observed with no strobes
    @(negedge clk);
    idle_inputs();
    push_status("R1");

    drv_write(32'hFFFF_FFFF, "R7");
    drv_update(64'h3FF0_0000_0000_0000, "R6");   // +1.0 clears all flags
    drv_update(64'h8000_0000_0000_0000, "R3");   // -0.0 -> N and Z
    drv_update(64'h0000_0000_0000_0000, "R3");   // +0.0 -> Z only
    drv_update(64'hBFF0_0000_0000_0000, "R2");   // -1.0 -> N
    drv_update(64'h7FF0_0000_0000_0000, "R4");   // +inf
    drv_update(64'hFFF0_0000_0000_0000, "R4");   // -inf -> N and I
    drv_update(64'h7FF8_0000_0000_0000, "R5");   // quiet NaN
    drv_update(64'hFFF0_0000_0000_0001, "R5");   // negative NaN, low mantissa
    drv_update(64'h7FE0_0000_0000_0000, "R4");   // large finite, no I
    drv_update(64'h0000_0000_0000_0001, "R3");   // smallest denormal, no Z
    drv_noise(64'h8000_0000_0000_0000);
    drv_noise(64'h7FF8_0000_0000_0000);
    drv_both(32'h1234_5678, 64'h8000_0000_0000_0000);
    drv_update(64'h7FF0_0000_0000_0000, "R6");   // keep 0x1234_5678 outside flags

    // every code against every flag combination
    for (int f = 0; f < 16; f++) begin
      drv_write({4'hA, 4'(f), 24'h5A_C3E1}, "R7");
      for (int c = 0; c < 64; c++) begin
        drv_eval(6'(c), 1'b1);
      end
    end

    // unsupported codes without a request: no error
    drv_eval(6'h3F, 1'b0);
    drv_eval(6'h02, 1'b0);
    drv_eval(6'h20, 1'b0);

    @(negedge clk);
    idle_inputs();
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got hang exp finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule